// File: doc/BRIEF.md
# 8-bit Subtract and Compare Unit

This block executes the subtract family of an 8-bit accumulator processor. There are three operations: plain subtract, subtract with incoming borrow, and compare. For each instruction it takes the opcode byte, the accumulator, the six general registers, a memory byte that has already been fetched through the HL pair, an immediate byte and the current carry flag. It returns the new accumulator value, the zero, subtract, half-borrow and borrow flags, write enables for the accumulator and for the flags, an illegal-opcode marker, and the number of clock cycles the instruction costs.

All three operations share one ripple-borrow subtractor. Compare runs the same subtraction as subtract but never asks for the accumulator to be written. Subtract with borrow feeds the incoming carry into the borrow input of the chain. The carry value used is the one that arrived with the instruction, and the new carry does not affect it.

Instructions enter on a valid/ready port, and results leave one cycle later on a second valid/ready port. Back-pressure rules: `in_ready` is high when the output register is empty or is being drained in the same cycle. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. A result stays on the output, unchanged, until a clock edge where `out_valid` and `out_ready` are both high.

Top module: `subcmp_unit`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An instruction taken at one clock edge shows its result with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, every output field holds its value.
- R2: Opcodes 0x90..0x97 subtract a source from the accumulator and write the result (`out_acc_we`=1). The low three opcode bits select the source: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory byte, 7=accumulator.
- R3: Opcodes 0x98..0x9F use the same source order and produce A - source - `in_carry`, with the accumulator written.
- R4: Opcodes 0xB8..0xBF (same source order) and 0xFE compare. They produce the same flags as a subtract with `out_flags_we`=1, but give `out_acc_we`=0 and `out_acc` equal to the incoming accumulator.
- R5: Opcodes 0xD6 (subtract), 0xDE (subtract with borrow) and 0xFE (compare) take `in_imm` as their operand.
- R6: `out_cycles` is 4 for a register or accumulator source, 8 for a memory-byte or immediate source, and 4 for an illegal opcode.
- R7: For a legal opcode, N is 1. Z is 1 exactly when the low 8 bits of the difference are zero.
- R8: H is 1 when the low nibble of A is less than the low nibble of the operand plus the borrow-in. The borrow-in is `in_carry` for subtract with borrow and 0 otherwise.
- R9: C is 1 when A is less than the operand plus the borrow-in, taken at 9-bit width. For example, A=0x00, operand 0xFF and borrow-in 1 gives result 0x00, Z=1, H=1, C=1.
- R10: Subtract and compare with the accumulator as source (0x97, 0xBF) always give Z=1, N=1, H=0, C=0.
- R11: Any other opcode gives `out_illegal`=1, `out_acc_we`=0, `out_flags_we`=0, `out_acc` equal to the incoming accumulator, and all four flag outputs at 0. The marker is carried on that instruction's single result beat.
- R12: While `rst_n` is low and on the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can take an instruction |
| in_opcode | input | 8 | Opcode byte |
| in_acc | input | 8 | Accumulator value |
| in_reg_b | input | 8 | Register B |
| in_reg_c | input | 8 | Register C |
| in_reg_d | input | 8 | Register D |
| in_reg_e | input | 8 | Register E |
| in_reg_h | input | 8 | Register H |
| in_reg_l | input | 8 | Register L |
| in_mem | input | 8 | Byte already read from the HL address |
| in_imm | input | 8 | Immediate byte following the opcode |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_acc | output | 8 | New accumulator value |
| out_acc_we | output | 1 | Write accumulator |
| out_flags_we | output | 1 | Write flags |
| out_z | output | 1 | Zero flag |
| out_n | output | 1 | Subtract flag |
| out_h | output | 1 | Half-borrow flag |
| out_c | output | 1 | Borrow flag |
| out_cycles | output | 4 | Clock cycles of the instruction |
| out_illegal | output | 1 | Opcode outside the group |

## Verification
There is only one pipeline register, so a wrong internal value appears on the very next result beat. A slip in the source order or the opcode decode shows up as a wrong `out_acc` or a wrong write enable. A bad borrow link shows up as wrong H or C only for the operand pairs that need a borrow to propagate, which is why the bench mixes exhaustive opcode sweeps with random operands. Errors in the handshake state show up in the same cycle as a mismatch between `out_valid` and the count of instructions in flight, or as an output field that changes during a stall.

// File: rtl/subcmp_pkg.sv
package subcmp_pkg;

  typedef enum logic [1:0] {
    OPK_NONE = 2'd0,
    OPK_SUB  = 2'd1,
    OPK_SBC  = 2'd2,
    OPK_CMP  = 2'd3
  } opk_e;

  // Values 0..7 follow the low three opcode bits; SRC_IMM is extra.
  typedef enum logic [3:0] {
    SRC_B   = 4'd0,
    SRC_C   = 4'd1,
    SRC_D   = 4'd2,
    SRC_E   = 4'd3,
    SRC_H   = 4'd4,
    SRC_L   = 4'd5,
    SRC_MEM = 4'd6,
    SRC_ACC = 4'd7,
    SRC_IMM = 4'd8
  } src_e;

  localparam int GP_REGS = 6;

endpackage

// File: rtl/subcmp_decode.sv
module subcmp_decode
  import subcmp_pkg::*;
#(
  parameter int REG_CYCLES = 4,
  parameter int MEM_CYCLES = 8,
  parameter int CYC_W      = 4
) (
  input  logic [7:0]       opcode,
  output opk_e             kind,
  output src_e             src,
  output logic             legal,
  output logic [CYC_W-1:0] cycles
);

  localparam logic [4:0] GRP_SUB = 5'b10010;
  localparam logic [4:0] GRP_SBC = 5'b10011;
  localparam logic [4:0] GRP_CMP = 5'b10111;

  always_comb begin
    kind  = OPK_NONE;
    src   = SRC_B;
    legal = 1'b0;
    if (opcode[7:3] == GRP_SUB) begin
      kind  = OPK_SUB;
      src   = src_e'({1'b0, opcode[2:0]});
      legal = 1'b1;
    end else if (opcode[7:3] == GRP_SBC) begin
      kind  = OPK_SBC;
      src   = src_e'({1'b0, opcode[2:0]});
      legal = 1'b1;
    end else if (opcode[7:3] == GRP_CMP) begin
      kind  = OPK_CMP;
      src   = src_e'({1'b0, opcode[2:0]});
      legal = 1'b1;
    end else begin
      case (opcode)
        8'hD6: begin kind = OPK_SUB; src = SRC_IMM; legal = 1'b1; end
        8'hDE: begin kind = OPK_SBC; src = SRC_IMM; legal = 1'b1; end
        8'hFE: begin kind = OPK_CMP; src = SRC_IMM; legal = 1'b1; end
        default: ;
      endcase
    end
  end

  // Sources needing an extra bus access cost the long count.
  always_comb begin
    if (legal && (src == SRC_MEM || src == SRC_IMM))
      cycles = CYC_W'(MEM_CYCLES);
    else
      cycles = CYC_W'(REG_CYCLES);
  end

endmodule

// File: rtl/subcmp_operand_mux.sv
module subcmp_operand_mux
  import subcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  src_e                       src,
  input  logic [GP_REGS-1:0][W-1:0]  gp_regs,
  input  logic [W-1:0]               acc,
  input  logic [W-1:0]               mem,
  input  logic [W-1:0]               imm,
  output logic [W-1:0]               operand
);

  always_comb begin
    case (src)
      SRC_B, SRC_C, SRC_D, SRC_E, SRC_H, SRC_L: operand = gp_regs[src[2:0]];
      SRC_MEM: operand = mem;
      SRC_ACC: operand = acc;
      SRC_IMM: operand = imm;
      default: operand = '0;
    endcase
  end

endmodule

// File: rtl/subcmp_borrow_chain.sv
module subcmp_borrow_chain #(
  parameter int W    = 8,
  parameter int HALF = W / 2
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  input  logic         borrow_in,
  output logic [W-1:0] diff,
  output logic         half_borrow,
  output logic         full_borrow
);

  logic [W:0] bw;
  assign bw[0] = borrow_in;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign diff[i]  = minuend[i] ^ subtrahend[i] ^ bw[i];
    assign bw[i+1]  = (~minuend[i] & (subtrahend[i] | bw[i])) | (subtrahend[i] & bw[i]);
  end

  assign half_borrow = bw[HALF];
  assign full_borrow = bw[W];

endmodule

// File: rtl/subcmp_unit.sv
module subcmp_unit
  import subcmp_pkg::*;
#(
  parameter  int W          = 8,
  parameter  int REG_CYCLES = 4,
  parameter  int MEM_CYCLES = 8,
  localparam int CYC_W      = $clog2(MEM_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_opcode,
  input  logic [W-1:0]     in_acc,
  input  logic [W-1:0]     in_reg_b,
  input  logic [W-1:0]     in_reg_c,
  input  logic [W-1:0]     in_reg_d,
  input  logic [W-1:0]     in_reg_e,
  input  logic [W-1:0]     in_reg_h,
  input  logic [W-1:0]     in_reg_l,
  input  logic [W-1:0]     in_mem,
  input  logic [W-1:0]     in_imm,
  input  logic             in_carry,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_acc,
  output logic             out_acc_we,
  output logic             out_flags_we,
  output logic             out_z,
  output logic             out_n,
  output logic             out_h,
  output logic             out_c,
  output logic [CYC_W-1:0] out_cycles,
  output logic             out_illegal
);

  localparam int HALF = W / 2;

  opk_e                      kind;
  src_e                      src;
  logic                      legal;
  logic [CYC_W-1:0]          cycles;
  logic [GP_REGS-1:0][W-1:0] gp_regs;
  logic [W-1:0]              operand;
  logic                      borrow_in;
  logic [W-1:0]              diff;
  logic                      hb, fb;
  logic                      take;

  logic [W-1:0]              nx_acc;
  logic                      nx_acc_we, nx_flags_we, nx_z, nx_h, nx_c, nx_n;

  assign gp_regs = {in_reg_l, in_reg_h, in_reg_e, in_reg_d, in_reg_c, in_reg_b};

  subcmp_decode #(
    .REG_CYCLES(REG_CYCLES),
    .MEM_CYCLES(MEM_CYCLES),
    .CYC_W     (CYC_W)
  ) u_dec (
    .opcode(in_opcode),
    .kind  (kind),
    .src   (src),
    .legal (legal),
    .cycles(cycles)
  );

  subcmp_operand_mux #(.W(W)) u_mux (
    .src    (src),
    .gp_regs(gp_regs),
    .acc    (in_acc),
    .mem    (in_mem),
    .imm    (in_imm),
    .operand(operand)
  );

  // Carry used is the one that came with the instruction, before update.
  assign borrow_in = (kind == OPK_SBC) ? in_carry : 1'b0;

  subcmp_borrow_chain #(.W(W), .HALF(HALF)) u_sub (
    .minuend    (in_acc),
    .subtrahend (operand),
    .borrow_in  (borrow_in),
    .diff       (diff),
    .half_borrow(hb),
    .full_borrow(fb)
  );

  always_comb begin
    nx_acc      = in_acc;
    nx_acc_we   = 1'b0;
    nx_flags_we = 1'b0;
    nx_z        = 1'b0;
    nx_n        = 1'b0;
    nx_h        = 1'b0;
    nx_c        = 1'b0;
    if (legal) begin
      nx_flags_we = 1'b1;
      nx_z        = (diff == '0);
      nx_n        = 1'b1;
      nx_h        = hb;
      nx_c        = fb;
      if (kind != OPK_CMP) begin
        nx_acc    = diff;
        nx_acc_we = 1'b1;
      end
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_acc      <= '0;
      out_acc_we   <= 1'b0;
      out_flags_we <= 1'b0;
      out_z        <= 1'b0;
      out_n        <= 1'b0;
      out_h        <= 1'b0;
      out_c        <= 1'b0;
      out_cycles   <= '0;
      out_illegal  <= 1'b0;
    end else if (take) begin
      out_acc      <= nx_acc;
      out_acc_we   <= nx_acc_we;
      out_flags_we <= nx_flags_we;
      out_z        <= nx_z;
      out_n        <= nx_n;
      out_h        <= nx_h;
      out_c        <= nx_c;
      out_cycles   <= cycles;
      out_illegal  <= !legal;
    end
  end

endmodule

// File: rtl/subcmp_unit_chk.sv
module subcmp_unit_chk #(
  parameter  int W          = 8,
  parameter  int REG_CYCLES = 4,
  parameter  int MEM_CYCLES = 8,
  localparam int CYC_W      = $clog2(MEM_CYCLES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [7:0]       in_opcode,
  input logic [W-1:0]     in_acc,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_acc,
  input logic             out_acc_we,
  input logic             out_flags_we,
  input logic             out_z,
  input logic             out_n,
  input logic             out_h,
  input logic             out_c,
  input logic [CYC_W-1:0] out_cycles,
  input logic             out_illegal
);

  logic acc_in;
  logic is_cmp;
  logic is_self;
  assign acc_in  = in_valid && in_ready;
  assign is_cmp  = (in_opcode[7:3] == 5'b10111) || (in_opcode == 8'hFE);
  assign is_self = (in_opcode == 8'h97) || (in_opcode == 8'hBF);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R12

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_acc) && $stable(out_z)
      && $stable(out_h) && $stable(out_c) && $stable(out_acc_we) && $stable(out_cycles)); // R1

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_in && is_cmp |=> out_valid && !out_acc_we && out_flags_we && out_acc == $past(in_acc)); // R4

  AST_N_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags_we |-> out_n); // R7

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_acc_we |-> out_z == (out_acc == '0)); // R7

  AST_SELF_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    acc_in && is_self |=> out_z && out_n && !out_h && !out_c); // R10

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_acc_we && !out_flags_we); // R11

  AST_CYCLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cycles == CYC_W'(REG_CYCLES)) || (out_cycles == CYC_W'(MEM_CYCLES))); // R6

endmodule

bind subcmp_unit subcmp_unit_chk #(
  .W(W), .REG_CYCLES(REG_CYCLES), .MEM_CYCLES(MEM_CYCLES)
) u_chk (.*);

// File: tb/subcmp_unit_test.sv
module subcmp_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_opcode = 8'h00;
  logic [7:0] in_acc = 8'h00;
  logic [7:0] in_reg_b = 8'h00, in_reg_c = 8'h00, in_reg_d = 8'h00;
  logic [7:0] in_reg_e = 8'h00, in_reg_h = 8'h00, in_reg_l = 8'h00;
  logic [7:0] in_mem = 8'h00, in_imm = 8'h00;
  logic       in_carry = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_acc;
  logic       out_acc_we, out_flags_we, out_z, out_n, out_h, out_c, out_illegal;
  logic [3:0] out_cycles;

  always #2 clk = ~clk; // 250 MHz

  subcmp_unit uut (.*);

  typedef struct {
    int    acc;
    int    acc_we;
    int    flags_we;
    int    z;
    int    n;
    int    h;
    int    c;
    int    cyc;
    int    ill;
    string acc_tag;
    string flag_tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  bit   bp_on  = 1'b0;
  int   cyc_count = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference from the requirement text.
  function automatic exp_t model(input int op, input int a, input int cin,
                                 input int b, input int c, input int d, input int e,
                                 input int h, input int l, input int m, input int im);
    exp_t r;
    int kind; // 0 illegal, 1 sub, 2 sbc, 3 compare
    int src;
    int opnd, bin, df, lo;
    kind = 0; src = op & 7;
    if (op >= 'h90 && op <= 'h97) kind = 1;
    else if (op >= 'h98 && op <= 'h9F) kind = 2;
    else if (op >= 'hB8 && op <= 'hBF) kind = 3;
    else if (op == 'hD6) begin kind = 1; src = 8; end
    else if (op == 'hDE) begin kind = 2; src = 8; end
    else if (op == 'hFE) begin kind = 3; src = 8; end
    case (src)
      0: opnd = b; 1: opnd = c; 2: opnd = d; 3: opnd = e;
      4: opnd = h; 5: opnd = l; 6: opnd = m; 7: opnd = a;
      default: opnd = im;
    endcase
    bin = (kind == 2) ? cin : 0;
    df  = a - opnd - bin;
    lo  = (a % 16) - (opnd % 16) - bin;
    r.acc_tag  = (kind == 1) ? "R2" : (kind == 2) ? "R3" : (kind == 3) ? "R4" : "R11";
    if (src == 8 && kind != 0) r.acc_tag = "R5";
    r.flag_tag = (op == 'h97 || op == 'hBF) ? "R10" : (src == 8 && kind == 2) ? "R9" : "R8";
    if (kind == 0) begin
      r.acc = a; r.acc_we = 0; r.flags_we = 0;
      r.z = 0; r.n = 0; r.h = 0; r.c = 0; r.cyc = 4; r.ill = 1;
    end else begin
      r.acc      = (kind == 3) ? a : (df & 255);
      r.acc_we   = (kind == 3) ? 0 : 1;
      r.flags_we = 1;
      r.z   = ((df & 255) == 0) ? 1 : 0;
      r.n   = 1;
      r.h   = (lo < 0) ? 1 : 0;
      r.c   = (df < 0) ? 1 : 0;
      r.cyc = (src >= 6 && src != 7) ? 8 : 4;
      r.ill = 0;
    end
    return r;
  endfunction

  // Monitor: away from the active edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R12", "out_valid in reset", int'(out_valid), 0);
      chk("R12", "in_ready in reset", int'(in_ready), 1);
    end else if (!done) begin
      chk("R1", "out_valid vs in flight", int'(out_valid), (q.size() > 0) ? 1 : 0);
      chk("R1", "in_ready", int'(in_ready), int'(!out_valid || out_ready));
      if (out_valid && q.size() > 0) begin
        exp_t f;
        f = q[0];
        chk(f.acc_tag, "out_acc", int'(out_acc), f.acc);
        chk("R4", "out_acc_we", int'(out_acc_we), f.acc_we);
        chk("R11", "out_flags_we", int'(out_flags_we), f.flags_we);
        chk((f.flag_tag == "R10") ? "R10" : "R7", "out_z", int'(out_z), f.z);
        chk("R7", "out_n", int'(out_n), f.n);
        chk(f.flag_tag, "out_h", int'(out_h), f.h);
        chk((f.flag_tag == "R8") ? "R9" : f.flag_tag, "out_c", int'(out_c), f.c);
        chk("R6", "out_cycles", int'(out_cycles), f.cyc);
        chk("R11", "out_illegal", int'(out_illegal), f.ill);
        if (out_ready) void'(q.pop_front());
      end
      if (in_valid && in_ready)
        q.push_back(model(in_opcode, in_acc, in_carry, in_reg_b, in_reg_c, in_reg_d,
                          in_reg_e, in_reg_h, in_reg_l, in_mem, in_imm));
    end
  end

  // Consumer side.
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = bp_on ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
  end

  task automatic issue(input logic [7:0] op, input logic [7:0] a, input logic cin,
                       input logic [7:0] m, input logic [7:0] im);
    bit got;
    in_valid = 1'b1; in_opcode = op; in_acc = a; in_carry = cin;
    in_mem = m; in_imm = im;
    got = 1'b0;
    while (!got) begin
      @(negedge clk);
      got = in_ready;
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic set_regs(input logic [7:0] b, c, d, e, h, l);
    in_reg_b = b; in_reg_c = c; in_reg_d = d;
    in_reg_e = e; in_reg_h = h; in_reg_l = l;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Watchdog.
  always @(posedge clk) begin
    cyc_count++;
    if (cyc_count > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R2 / R3 / R4: full source sweep with distinct register values
    set_regs(8'h11, 8'h23, 8'h3C, 8'h48, 8'h5F, 8'h60);
    for (int op = 'h90; op <= 'hBF; op++) begin
      for (int cin = 0; cin < 2; cin++) begin
        issue(8'(op), 8'h47, cin[0], 8'h29, 8'h00);
        issue(8'(op), 8'h03, cin[0], 8'hF1, 8'h00);
      end
    end

    // R5 immediates, R9 corner 0x00 - 0xFF - 1
    issue(8'hD6, 8'h80, 1'b1, 8'h00, 8'h01);
    issue(8'hDE, 8'h00, 1'b1, 8'h00, 8'hFF);
    issue(8'hDE, 8'h10, 1'b1, 8'h00, 8'h0F);
    issue(8'hFE, 8'h42, 1'b0, 8'h00, 8'h42);
    issue(8'hFE, 8'h41, 1'b1, 8'h00, 8'h42);

    // R10 self subtract/compare with carry set
    issue(8'h97, 8'hA5, 1'b1, 8'h00, 8'h00);
    issue(8'hBF, 8'h00, 1'b1, 8'h00, 8'h00);
    issue(8'h9F, 8'h5A, 1'b1, 8'h00, 8'h00);

    // R11 opcodes around the group
    issue(8'h00, 8'h77, 1'b1, 8'h00, 8'h00);
    issue(8'h8F, 8'h77, 1'b0, 8'h00, 8'h00);
    issue(8'hA0, 8'h77, 1'b1, 8'h00, 8'h00);
    issue(8'hB7, 8'h77, 1'b0, 8'h00, 8'h00);
    issue(8'hD7, 8'h77, 1'b1, 8'h00, 8'h00);
    issue(8'hFF, 8'h77, 1'b1, 8'h00, 8'h00);

    // R1 back-pressure with random traffic
    bp_on = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      set_regs(8'($urandom), 8'($urandom), 8'($urandom),
               8'($urandom), 8'($urandom), 8'($urandom));
      issue(8'($urandom_range(0, 255)), 8'($urandom), 1'($urandom),
            8'($urandom), 8'($urandom));
      if ($urandom_range(0, 3) == 0) begin
        @(posedge clk); #1;
      end
    end
    bp_on = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R1", "drained queue", q.size(), 0);
    finish_run();
  end

endmodule